// File: doc/BRIEF.md
# MESI Cache-Side Line Controller

This block keeps a small direct-mapped array of cache lines for one processor node and runs the node's half of a directory-based MESI protocol. Each line holds a tag, one data word, a coherence state and a busy flag. The local processor issues reads, writes and three directory-bound operations: evict, get-shared and get-exclusive. Every request gets a pass/fail answer on the next cycle. None of them waits.

A directory-bound operation locks its line with the busy flag and places a request in a one-entry outgoing slot. That slot drives a valid/ready channel toward the directory. The directory answers on an incoming message port with a fill, an evict acknowledgement or a no-op. It can also snoop a line at any time, including while that line is busy. An exclusive snoop returns the line's data on a separate snoop-data output one cycle later.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (code 0) and not busy. `lrsp_valid`, `dreq_valid` and `snp_valid` are low.
- R2: The line index is address bits [3:0] and the tag is bits [11:4]. A read (op 0) hits only when the line is not Invalid and its tag equals the address tag. Every local request is answered one cycle later on `lrsp_valid`. `lrsp_data` carries the line data on a read hit and zero in every other case.
- R3: A write (op 1) succeeds only when the line is Exclusive (2) or Modified (3), the tag matches and the line is not busy. On success the word is replaced and the state becomes Modified. On failure nothing changes.
- R4: An evict (op 2) is accepted only for a line that is not Invalid and not busy. It sets busy and queues request kind 0, carrying the line's own address {tag, index} and its data.
- R5: A get-shared (op 3) is accepted only for an Invalid line that is not busy. It stores the new tag, sets busy and queues request kind 1 with the address and zero data.
- R6: A get-exclusive (op 4) is accepted for a line that is not busy and is either Invalid, or Shared (1) with a matching tag. It stores the tag, sets busy and queues request kind 2.
- R7: A fill message (kind 0) gives the line the state in `dmsg_state` and clears busy. A line that was Invalid also takes the message's tag and data. A line that was not Invalid keeps its data.
- R8: An evict acknowledgement (kind 1) makes the line Invalid and clears busy. A no-op (kind 2) only clears busy.
- R9: A shared snoop (kind 3) makes a Shared line with a matching tag Invalid. In every other case it has no effect.
- R10: An exclusive snoop (kind 4) on an Exclusive or Modified line with a matching tag sets the line to `dmsg_state` (Shared or Invalid). One cycle later it raises `snp_valid` with the old data. In every other case it has no effect, and `snp_data` is zero whenever `snp_valid` is low.
- R11: When `dmsg_valid` and `lreq_valid` are both high, the directory message is applied and the local request fails with no effect. Snoops apply whether or not the line is busy.
- R12: The outgoing slot holds one request. Its contents stay stable while `dreq_valid` is high and `dreq_ready` is low. A directory-bound operation fails when the slot is occupied and not draining in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request present |
| lreq_op | input | 3 | 0 read, 1 write, 2 evict, 3 get-shared, 4 get-exclusive |
| lreq_addr | input | 12 | Local request address |
| lreq_wdata | input | 32 | Write data |
| lrsp_valid | output | 1 | Local answer present |
| lrsp_ok | output | 1 | Local request succeeded or hit |
| lrsp_data | output | 32 | Read data on a hit |
| dreq_valid | output | 1 | Directory request present |
| dreq_ready | input | 1 | Directory takes the request |
| dreq_kind | output | 2 | 0 evict, 1 get-shared, 2 get-exclusive |
| dreq_addr | output | 12 | Request address |
| dreq_data | output | 32 | Evicted data |
| dmsg_valid | input | 1 | Directory message present |
| dmsg_kind | input | 3 | 0 fill, 1 evict ack, 2 no-op, 3 shared snoop, 4 exclusive snoop |
| dmsg_addr | input | 12 | Message address |
| dmsg_state | input | 2 | Target state for fill and exclusive snoop |
| dmsg_data | input | 32 | Fill data |
| snp_valid | output | 1 | Exclusive snoop returned data |
| snp_data | output | 32 | Data taken from the snooped line |

## Verification
Four properties are checked on every cycle:
- every local request receives an answer on the next cycle;
- a local request that coincides with a directory message never reports success;
- a held directory request does not change until it is taken;
- snoop data appears only after an exclusive snoop, and a new directory request only follows a local request.

Reset clearing of each line is also checked as a property. The state rules can only be shown by the bench's scenarios. These are the busy locking, a snoop invalidating a line while its get-exclusive is outstanding, a fill keeping Shared data, a no-op leaving the line valid, and aliasing addresses on one index. The bench runs those scenarios against its own line model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    localparam int unsigned LINES  = 16;
    localparam int unsigned TAG_W  = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned ADDR_W = TAG_W + IDX_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        LOP_READ  = 3'd0,
        LOP_WRITE = 3'd1,
        LOP_EVICT = 3'd2,
        LOP_GET_S = 3'd3,
        LOP_GET_X = 3'd4
    } lop_e;

    typedef enum logic [1:0] {
        DRQ_EVICT = 2'd0,
        DRQ_GET_S = 2'd1,
        DRQ_GET_X = 2'd2
    } drq_e;

    typedef enum logic [2:0] {
        DMSG_FILL   = 3'd0,
        DMSG_EV_ACK = 3'd1,
        DMSG_NOP    = 3'd2,
        DMSG_SNP_S  = 3'd3,
        DMSG_SNP_X  = 3'd4
    } dmsg_e;

    typedef struct packed {
        tag_t  tag;
        data_t data;
        mesi_e st;
        logic  busy;
    } line_t;

    typedef struct packed {
        drq_e  kind;
        addr_t addr;
        data_t data;
    } dreq_t;

    function automatic idx_t addr_idx(addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t addr_tag(addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic logic owns(mesi_e s);
        return (s == ST_E) || (s == ST_M);
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array import mesi_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line,
    input  idx_t  rd_a_idx,
    output line_t rd_a_line,
    input  idx_t  rd_b_idx,
    output line_t rd_b_line
);

    line_t lines [LINES];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LINES; k++) begin
            if (rst) begin
                lines[k] <= '{tag: '0, data: '0, st: ST_I, busy: 1'b0};
            end else if (wr_en && wr_idx == idx_t'(k)) begin
                lines[k] <= wr_line;
            end
        end
    end

    assign rd_a_line = lines[rd_a_idx];
    assign rd_b_line = lines[rd_b_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_rst_chk
        // R1
        line_reset_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (lines[g].st == ST_I && !lines[g].busy));
    end

endmodule

// File: rtl/mesi_local_ctrl.sv
module mesi_local_ctrl import mesi_pkg::*; (
    input  logic  req_valid,
    input  logic  [2:0] req_op,
    input  addr_t req_addr,
    input  data_t req_wdata,
    input  line_t line,
    input  logic  slot_free,
    input  logic  blocked,
    output logic  ok,
    output data_t rdata,
    output logic  upd_en,
    output line_t upd_line,
    output logic  send,
    output dreq_t send_req
);

    logic tag_eq;
    logic hit;
    logic lockable;

    assign tag_eq   = (line.tag == addr_tag(req_addr));
    assign hit      = (line.st != ST_I) && tag_eq;
    assign lockable = !line.busy && slot_free;

    always_comb begin
        ok       = 1'b0;
        rdata    = '0;
        upd_en   = 1'b0;
        upd_line = line;
        send     = 1'b0;
        send_req = '{kind: DRQ_GET_S, addr: req_addr, data: '0};
        if (req_valid && !blocked) begin
            case (lop_e'(req_op))
                LOP_READ: begin
                    if (hit) begin
                        ok    = 1'b1;
                        rdata = line.data;
                    end
                end
                LOP_WRITE: begin
                    if (hit && owns(line.st) && !line.busy) begin
                        ok            = 1'b1;
                        upd_en        = 1'b1;
                        upd_line.data = req_wdata;
                        upd_line.st   = ST_M;
                    end
                end
                LOP_EVICT: begin
                    if (line.st != ST_I && lockable) begin
                        ok            = 1'b1;
                        upd_en        = 1'b1;
                        upd_line.busy = 1'b1;
                        send          = 1'b1;
                        send_req      = '{kind: DRQ_EVICT,
                                          addr: {line.tag, addr_idx(req_addr)},
                                          data: line.data};
                    end
                end
                LOP_GET_S: begin
                    if (line.st == ST_I && lockable) begin
                        ok            = 1'b1;
                        upd_en        = 1'b1;
                        upd_line.busy = 1'b1;
                        upd_line.tag  = addr_tag(req_addr);
                        send          = 1'b1;
                        send_req      = '{kind: DRQ_GET_S, addr: req_addr, data: '0};
                    end
                end
                LOP_GET_X: begin
                    if (lockable && (line.st == ST_I || (line.st == ST_S && tag_eq))) begin
                        ok            = 1'b1;
                        upd_en        = 1'b1;
                        upd_line.busy = 1'b1;
                        upd_line.tag  = addr_tag(req_addr);
                        send          = 1'b1;
                        send_req      = '{kind: DRQ_GET_X, addr: req_addr, data: '0};
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_msg_apply.sv
module mesi_msg_apply import mesi_pkg::*; (
    input  logic  msg_valid,
    input  logic  [2:0] msg_kind,
    input  addr_t msg_addr,
    input  logic  [1:0] msg_state,
    input  data_t msg_data,
    input  line_t line,
    output logic  upd_en,
    output line_t upd_line,
    output logic  snp_hit,
    output data_t snp_data
);

    logic tag_eq;

    assign tag_eq = (line.tag == addr_tag(msg_addr));

    always_comb begin
        upd_en   = 1'b0;
        upd_line = line;
        snp_hit  = 1'b0;
        snp_data = '0;
        if (msg_valid) begin
            case (dmsg_e'(msg_kind))
                DMSG_FILL: begin
                    upd_en        = 1'b1;
                    upd_line.busy = 1'b0;
                    upd_line.st   = mesi_e'(msg_state);
                    if (line.st == ST_I) begin
                        upd_line.tag  = addr_tag(msg_addr);
                        upd_line.data = msg_data;
                    end
                end
                DMSG_EV_ACK: begin
                    upd_en        = 1'b1;
                    upd_line.busy = 1'b0;
                    upd_line.st   = ST_I;
                end
                DMSG_NOP: begin
                    upd_en        = 1'b1;
                    upd_line.busy = 1'b0;
                end
                DMSG_SNP_S: begin
                    if (line.st == ST_S && tag_eq) begin
                        upd_en      = 1'b1;
                        upd_line.st = ST_I;
                    end
                end
                DMSG_SNP_X: begin
                    if (owns(line.st) && tag_eq) begin
                        upd_en      = 1'b1;
                        upd_line.st = mesi_e'(msg_state);
                        snp_hit     = 1'b1;
                        snp_data    = line.data;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_dreq_slot.sv
module mesi_dreq_slot import mesi_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  dreq_t load_req,
    input  logic  ready,
    output logic  out_valid,
    output dreq_t out_req,
    output logic  free
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_req   <= '{kind: DRQ_EVICT, addr: '0, data: '0};
        end else if (load) begin
            out_valid <= 1'b1;
            out_req   <= load_req;
        end else if (out_valid && ready) begin
            out_valid <= 1'b0;
        end
    end

    assign free = !out_valid || ready;

    // R12
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ready) |=> (out_valid && $stable(out_req)));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl import mesi_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                lreq_valid,
    input  logic [2:0]          lreq_op,
    input  logic [ADDR_W-1:0]   lreq_addr,
    input  logic [DATA_W-1:0]   lreq_wdata,
    output logic                lrsp_valid,
    output logic                lrsp_ok,
    output logic [DATA_W-1:0]   lrsp_data,
    output logic                dreq_valid,
    input  logic                dreq_ready,
    output logic [1:0]          dreq_kind,
    output logic [ADDR_W-1:0]   dreq_addr,
    output logic [DATA_W-1:0]   dreq_data,
    input  logic                dmsg_valid,
    input  logic [2:0]          dmsg_kind,
    input  logic [ADDR_W-1:0]   dmsg_addr,
    input  logic [1:0]          dmsg_state,
    input  logic [DATA_W-1:0]   dmsg_data,
    output logic                snp_valid,
    output logic [DATA_W-1:0]   snp_data
);

    line_t la_line, lb_line, loc_line, msg_line, wr_line;
    logic  loc_ok, loc_upd, loc_send, msg_upd, msg_snp, slot_free, wr_en;
    data_t loc_rdata, msg_sdata;
    dreq_t loc_req, slot_req;
    idx_t  wr_idx;

    mesi_line_array i_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_line   (wr_line),
        .rd_a_idx  (addr_idx(lreq_addr)),
        .rd_a_line (la_line),
        .rd_b_idx  (addr_idx(dmsg_addr)),
        .rd_b_line (lb_line)
    );

    mesi_local_ctrl i_local (
        .req_valid (lreq_valid),
        .req_op    (lreq_op),
        .req_addr  (lreq_addr),
        .req_wdata (lreq_wdata),
        .line      (la_line),
        .slot_free (slot_free),
        .blocked   (dmsg_valid),
        .ok        (loc_ok),
        .rdata     (loc_rdata),
        .upd_en    (loc_upd),
        .upd_line  (loc_line),
        .send      (loc_send),
        .send_req  (loc_req)
    );

    mesi_msg_apply i_msg (
        .msg_valid (dmsg_valid),
        .msg_kind  (dmsg_kind),
        .msg_addr  (dmsg_addr),
        .msg_state (dmsg_state),
        .msg_data  (dmsg_data),
        .line      (lb_line),
        .upd_en    (msg_upd),
        .upd_line  (msg_line),
        .snp_hit   (msg_snp),
        .snp_data  (msg_sdata)
    );

    mesi_dreq_slot i_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (loc_send),
        .load_req  (loc_req),
        .ready     (dreq_ready),
        .out_valid (dreq_valid),
        .out_req   (slot_req),
        .free      (slot_free)
    );

    assign wr_en   = msg_upd | loc_upd;
    assign wr_idx  = msg_upd ? addr_idx(dmsg_addr) : addr_idx(lreq_addr);
    assign wr_line = msg_upd ? msg_line : loc_line;

    assign dreq_kind = slot_req.kind;
    assign dreq_addr = slot_req.addr;
    assign dreq_data = slot_req.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            lrsp_valid <= 1'b0;
            lrsp_ok    <= 1'b0;
            lrsp_data  <= '0;
            snp_valid  <= 1'b0;
            snp_data   <= '0;
        end else begin
            lrsp_valid <= lreq_valid;
            lrsp_ok    <= loc_ok;
            lrsp_data  <= loc_rdata;
            snp_valid  <= msg_snp;
            snp_data   <= msg_snp ? msg_sdata : '0;
        end
    end

    // R2
    lrsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        lreq_valid |=> lrsp_valid);

    // R11
    dir_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (lreq_valid && dmsg_valid) |=> !lrsp_ok);

    // R10
    snp_source_chk: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> $past(dmsg_valid && dmsg_kind == 3'(DMSG_SNP_X)));

    // R4
    dreq_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dreq_valid) |-> $past(lreq_valid));

endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
    import mesi_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              lreq_valid = 1'b0;
    logic [2:0]        lreq_op = '0;
    logic [ADDR_W-1:0] lreq_addr = '0;
    logic [DATA_W-1:0] lreq_wdata = '0;
    logic              lrsp_valid, lrsp_ok;
    logic [DATA_W-1:0] lrsp_data;
    logic              dreq_valid;
    logic              dreq_ready = 1'b1;
    logic [1:0]        dreq_kind;
    logic [ADDR_W-1:0] dreq_addr;
    logic [DATA_W-1:0] dreq_data;
    logic              dmsg_valid = 1'b0;
    logic [2:0]        dmsg_kind = '0;
    logic [ADDR_W-1:0] dmsg_addr = '0;
    logic [1:0]        dmsg_state = '0;
    logic [DATA_W-1:0] dmsg_data = '0;
    logic              snp_valid;
    logic [DATA_W-1:0] snp_data;

    mesi_line_ctrl i_mesi_line_ctrl (
        .clk(clk), .rst(rst),
        .lreq_valid(lreq_valid), .lreq_op(lreq_op), .lreq_addr(lreq_addr), .lreq_wdata(lreq_wdata),
        .lrsp_valid(lrsp_valid), .lrsp_ok(lrsp_ok), .lrsp_data(lrsp_data),
        .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_kind(dreq_kind),
        .dreq_addr(dreq_addr), .dreq_data(dreq_data),
        .dmsg_valid(dmsg_valid), .dmsg_kind(dmsg_kind), .dmsg_addr(dmsg_addr),
        .dmsg_state(dmsg_state), .dmsg_data(dmsg_data),
        .snp_valid(snp_valid), .snp_data(snp_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    int                m_tag  [LINES];
    logic [DATA_W-1:0] m_data [LINES];
    int                m_st   [LINES];
    bit                m_busy [LINES];
    int                m_out  [LINES];
    bit                m_sent [LINES];
    bit                sv = 0;
    int                skind = 0;
    int                saddr = 0;
    logic [DATA_W-1:0] sdata = '0;

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic cyc(input bit lv, input int op, input int la, input logic [DATA_W-1:0] wd,
                       input bit mv, input int mk, input int ma, input int ms,
                       input logic [DATA_W-1:0] md, input bit rdy, input string req);
        int li = ma % LINES;
        int ri = la % LINES;
        int mt = ma / LINES;
        int lt = la / LINES;
        bit eok = 0;
        bit esnp = 0;
        bit ld = 0;
        bit hit = 0;
        bit sfree = !sv || rdy;
        int lk = 0;
        int lad = 0;
        logic [DATA_W-1:0] erd = '0;
        logic [DATA_W-1:0] esd = '0;
        logic [DATA_W-1:0] ldat = '0;
        @(negedge clk);
        lreq_valid = lv; lreq_op = 3'(op); lreq_addr = ADDR_W'(la); lreq_wdata = wd;
        dmsg_valid = mv; dmsg_kind = 3'(mk); dmsg_addr = ADDR_W'(ma);
        dmsg_state = 2'(ms); dmsg_data = md; dreq_ready = rdy;
        if (mv) begin
            case (mk)
                0: begin
                    if (m_st[li] == 0) begin m_tag[li] = mt; m_data[li] = md; end
                    m_st[li] = ms; m_busy[li] = 0; m_out[li] = 0; m_sent[li] = 0;
                end
                1: begin m_st[li] = 0; m_busy[li] = 0; m_out[li] = 0; m_sent[li] = 0; end
                2: begin m_busy[li] = 0; m_out[li] = 0; m_sent[li] = 0; end
                3: if (m_st[li] == 1 && m_tag[li] == mt) m_st[li] = 0;
                default: if (m_st[li] >= 2 && m_tag[li] == mt) begin
                    esnp = 1; esd = m_data[li]; m_st[li] = ms;
                end
            endcase
        end else if (lv) begin
            hit = (m_st[ri] != 0) && (m_tag[ri] == lt);
            case (op)
                0: if (hit) begin eok = 1; erd = m_data[ri]; end
                1: if (hit && m_st[ri] >= 2 && !m_busy[ri]) begin
                    eok = 1; m_data[ri] = wd; m_st[ri] = 3;
                end
                2: if (m_st[ri] != 0 && !m_busy[ri] && sfree) begin
                    eok = 1; m_busy[ri] = 1; m_out[ri] = 1; m_sent[ri] = 0;
                    ld = 1; lk = 0; lad = m_tag[ri] * LINES + ri; ldat = m_data[ri];
                end
                3: if (m_st[ri] == 0 && !m_busy[ri] && sfree) begin
                    eok = 1; m_busy[ri] = 1; m_out[ri] = 2; m_sent[ri] = 0; m_tag[ri] = lt;
                    ld = 1; lk = 1; lad = la;
                end
                4: if (!m_busy[ri] && sfree &&
                       (m_st[ri] == 0 || (m_st[ri] == 1 && m_tag[ri] == lt))) begin
                    eok = 1; m_busy[ri] = 1; m_out[ri] = 3; m_sent[ri] = 0; m_tag[ri] = lt;
                    ld = 1; lk = 2; lad = la;
                end
                default: ;
            endcase
        end
        if (sv && rdy) begin
            sv = 0;
            m_sent[saddr % LINES] = 1;
        end
        if (ld) begin
            sv = 1; skind = lk; saddr = lad; sdata = ldat;
        end
        @(posedge clk);
        #1;
        chk(lrsp_valid === lv, req, "lrsp_valid", longint'(lrsp_valid), longint'(lv));
        chk(lrsp_ok === eok, req, "lrsp_ok", longint'(lrsp_ok), longint'(eok));
        chk(lrsp_data === erd, req, "lrsp_data", longint'(lrsp_data), longint'(erd));
        chk(snp_valid === esnp, req, "snp_valid", longint'(snp_valid), longint'(esnp));
        chk(snp_data === esd, req, "snp_data", longint'(snp_data), longint'(esd));
        chk(dreq_valid === sv, req, "dreq_valid", longint'(dreq_valid), longint'(sv));
        if (sv) begin
            chk(int'(dreq_kind) == skind, req, "dreq_kind", longint'(dreq_kind), longint'(skind));
            chk(int'(dreq_addr) == saddr, req, "dreq_addr", longint'(dreq_addr), longint'(saddr));
            chk(dreq_data === sdata, req, "dreq_data", longint'(dreq_data), longint'(sdata));
        end
    endtask

    task automatic idle(input string req);
        cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a;
        int b;
        void'($urandom(32'd4242));
        for (int k = 0; k < LINES; k++) begin
            m_tag[k] = 0; m_data[k] = '0; m_st[k] = 0; m_busy[k] = 0; m_out[k] = 0; m_sent[k] = 0;
        end
        a = 12'h035;
        b = 12'h045;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: outputs quiet right after reset
        chk(!lrsp_valid && !dreq_valid && !snp_valid, "R1", "outputs after reset",
            longint'({lrsp_valid, dreq_valid, snp_valid}), 0);
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R1");
        // R5 get-shared, held while not ready (R12)
        cyc(1, 3, a, '0, 0, 0, 0, 0, '0, 0, "R5");
        cyc(1, 1, a, 32'hDEAD, 0, 0, 0, 0, '0, 0, "R3");
        cyc(1, 3, 12'h016, '0, 0, 0, 0, 0, '0, 0, "R12");
        cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, "R12");
        // R7 fill Exclusive
        cyc(0, 0, 0, '0, 1, 0, a, 2, 32'h1234_5678, 1, "R7");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R2");
        cyc(1, 0, b, '0, 0, 0, 0, 0, '0, 1, "R2");
        cyc(1, 1, a, 32'hCAFE_0001, 0, 0, 0, 0, '0, 1, "R3");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R3");
        // R11 message wins over a local hit
        cyc(1, 0, a, '0, 1, 3, 12'h0F9, 0, '0, 1, "R11");
        // R10 exclusive snoop to Shared
        cyc(0, 0, 0, '0, 1, 4, a, 1, '0, 1, "R10");
        cyc(1, 1, a, 32'h0BAD, 0, 0, 0, 0, '0, 1, "R3");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R10");
        // R6 get-exclusive from Shared, snooped while busy (R9, R11)
        cyc(1, 4, a, '0, 0, 0, 0, 0, '0, 1, "R6");
        idle("R6");
        cyc(0, 0, 0, '0, 1, 3, a, 0, '0, 1, "R9");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R9");
        cyc(0, 0, 0, '0, 1, 0, a, 2, 32'h0000_0055, 1, "R7");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R7");
        // R4 evict, second evict refused while busy; R8 no-op and ack
        cyc(1, 2, a, '0, 0, 0, 0, 0, '0, 1, "R4");
        cyc(1, 2, a, '0, 0, 0, 0, 0, '0, 1, "R4");
        cyc(0, 0, 0, '0, 1, 2, a, 0, '0, 1, "R8");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R8");
        cyc(1, 2, a, '0, 0, 0, 0, 0, '0, 1, "R4");
        idle("R4");
        cyc(0, 0, 0, '0, 1, 1, a, 0, '0, 1, "R8");
        cyc(1, 0, a, '0, 0, 0, 0, 0, '0, 1, "R8");
        // R9 shared snoop with a mismatched tag has no effect
        cyc(1, 3, b, '0, 0, 0, 0, 0, '0, 1, "R5");
        idle("R5");
        cyc(0, 0, 0, '0, 1, 0, b, 1, 32'h7777, 1, "R7");
        cyc(0, 0, 0, '0, 1, 3, a, 0, '0, 1, "R9");
        cyc(1, 0, b, '0, 0, 0, 0, 0, '0, 1, "R9");

        for (int n = 0; n < 6000; n++) begin
            bit mv = 0;
            bit lv;
            int mk = 0, ma = 0, ms = 0, pick = -1, r, op, la;
            logic [DATA_W-1:0] md = DATA_W'($urandom);
            r = $urandom % 10;
            if (r < 3) begin
                int s = $urandom % LINES;
                for (int k = 0; k < LINES; k++) begin
                    int c = (s + k) % LINES;
                    if (pick < 0 && m_out[c] != 0 && m_sent[c]) pick = c;
                end
                if (pick >= 0) begin
                    mv = 1;
                    ma = m_tag[pick] * LINES + pick;
                    case (m_out[pick])
                        1: mk = 1 + ($urandom % 2);
                        2: begin mk = 0; ms = 1 + ($urandom % 2); end
                        default: begin mk = 0; ms = 2; end
                    endcase
                end
            end else if (r < 5) begin
                int c = $urandom % 8;
                mv = 1;
                mk = 3 + ($urandom % 2);
                ms = $urandom % 2;
                ma = ((($urandom % 4) == 0) ? int'($urandom % 3) : m_tag[c]) * LINES + c;
            end
            lv = ($urandom % 10) < 8;
            op = $urandom % 5;
            la = int'($urandom % 3) * LINES + int'($urandom % 8);
            cyc(lv, op, la, DATA_W'($urandom), mv, mk, ma, ms, md, ($urandom % 5) != 0, "random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule